// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block services a translation-buffer miss in hardware. It takes the missing virtual page number and the base address of the current process's page directory. It fetches the directory word for the upper half of the page number. When that word is a non-null pointer, it fetches the page table entry for the lower half. It then reports one of three outcomes on a one-cycle completion strobe: a translation ready to refill the buffer, a page fault for a page that is not resident, or an illegal access to a page that does not exist.

Memory is reached through a simple read port. The walker raises a read enable with a byte address and holds both until the memory answers with a valid strobe and the data word. The memory may answer in the first cycle of the request or any number of cycles later. While a walk is in flight the walker reports itself busy and ignores further miss requests.

Top module: `pgwalk_top`

## Requirements
- R1: The first read of a walk uses byte address `dir_base + 4 * vpn[19:10]`.
- R2: When the directory word is non-zero, the second read uses byte address `dir_word + 4 * vpn[9:0]`.
- R3: A directory word of zero ends the walk after that single read, with result code 2 (illegal).
- R4: A page table entry with bit 23 (exists) set and bit 22 (resident) set gives result code 0 (refill). `res_ppn` then carries entry bits 19:0, and `res_vpn` echoes the requested page number.
- R5: An entry with bit 23 set and bit 22 clear gives result code 1 (page fault), and `res_ppn` is zero.
- R6: An entry with bit 23 clear gives result code 2 (illegal) whatever bit 22 holds. Bits 31:24, 21 and 20 never change the outcome.
- R7: A page number above 0xBFFFF gives result code 2 with no memory read, and `done` is high in the cycle right after the request is taken. Code 3 is never produced.
- R8: `done` is high for exactly one cycle per walk, and the result outputs are valid in that cycle.
- R9: `busy` is high from the cycle after a request is taken through the `done` cycle, and low otherwise. No read is issued while `busy` is low.
- R10: A miss request that arrives while `busy` is high is ignored. It changes neither the running walk's outcome nor starts a later walk.
- R11: `mem_rd_en` and `mem_addr` stay steady until `mem_rvalid` is seen. From a request to `done`, the walk takes one cycle per read cycle spent, so with a latency of L cycles per read it takes 2L, L or 0 cycles.
- R12: While reset is asserted, and after it is released, `busy`, `done` and `mem_rd_en` are low, including when reset cuts a walk short.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| miss_req | input | 1 | Miss request strobe, taken when idle |
| miss_vpn | input | 20 | Virtual page number that missed |
| dir_base | input | 32 | Byte address of the page directory |
| mem_rd_en | output | 1 | Read request, held until answered |
| mem_addr | output | 32 | Byte address of the word to read |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 32 | Read data word |
| busy | output | 1 | Walk in progress |
| done | output | 1 | One-cycle completion strobe |
| result | output | 2 | 0 refill, 1 page fault, 2 illegal |
| res_ppn | output | 20 | Physical page number on refill, else zero |
| res_vpn | output | 20 | Page number of the completed walk |

## Verification
The in-line assertions watch, on every cycle, the timing rules of the walk:
- the completion strobe lasts one cycle and falls inside `busy`;
- no read is issued while idle;
- the read request and address stay steady until answered;
- an out-of-range page completes at once as illegal;
- non-refill outcomes carry a zero page number, and code 3 never appears.

Only the bench's scenarios can show that the two addresses are formed from the right index fields and that the status-bit combinations map to the right outcomes. They also show that reserved and bookkeeping bits are ignored, and that a request made mid-walk leaves the walk unchanged.

// File: rtl/pgwalk_pkg.sv
package pgwalk_pkg;

  typedef enum logic [1:0] {
    WALK_REFILL  = 2'd0,
    WALK_FAULT   = 2'd1,
    WALK_ILLEGAL = 2'd2
  } walk_res_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_DIR  = 2'd1,
    ST_PTE  = 2'd2,
    ST_DONE = 2'd3
  } walk_state_e;

  localparam int unsigned ENTRY_EXISTS_BIT   = 23;
  localparam int unsigned ENTRY_RESIDENT_BIT = 22;

endpackage

// File: rtl/pgwalk_rstsync.sv
module pgwalk_rstsync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = chain_q[STAGES-1];

endmodule

// File: rtl/pgwalk_addr.sv
module pgwalk_addr #(
  parameter int unsigned VPN_W     = 20,
  parameter int unsigned DIR_IDX_W = 10,
  parameter int unsigned ADDR_W    = 32,
  parameter int unsigned WORD_SHIFT = 2
) (
  input  logic              sel_table,
  input  logic [VPN_W-1:0]  vpn,
  input  logic [ADDR_W-1:0] dir_base,
  input  logic [ADDR_W-1:0] table_base,
  output logic [ADDR_W-1:0] addr
);

  localparam int unsigned TBL_IDX_W = VPN_W - DIR_IDX_W;

  logic [DIR_IDX_W-1:0] dir_idx;
  logic [TBL_IDX_W-1:0] tbl_idx;
  logic [ADDR_W-1:0]    dir_off;
  logic [ADDR_W-1:0]    tbl_off;

  always_comb begin
    dir_idx = vpn[VPN_W-1:TBL_IDX_W];
    tbl_idx = vpn[TBL_IDX_W-1:0];
    dir_off = ADDR_W'(dir_idx) << WORD_SHIFT;
    tbl_off = ADDR_W'(tbl_idx) << WORD_SHIFT;
    if (sel_table) addr = table_base + tbl_off;
    else           addr = dir_base + dir_off;
  end

endmodule

// File: rtl/pgwalk_decode.sv
module pgwalk_decode
  import pgwalk_pkg::*;
#(
  parameter int unsigned WORD_W = 32,
  parameter int unsigned PPN_W  = 20
) (
  input  logic [WORD_W-1:0] entry,
  output walk_res_e         outcome,
  output logic [PPN_W-1:0]  ppn
);

  logic exists;
  logic resident;
  logic unused_status;

  assign exists        = entry[ENTRY_EXISTS_BIT];
  assign resident      = entry[ENTRY_RESIDENT_BIT];
  assign unused_status = ^entry[WORD_W-1:PPN_W];

  always_comb begin
    ppn = '0;
    if (!exists) begin
      outcome = WALK_ILLEGAL;
    end else if (!resident) begin
      outcome = WALK_FAULT;
    end else begin
      outcome = WALK_REFILL;
      ppn     = entry[PPN_W-1:0];
    end
  end

  always_comb begin
    assert (outcome != WALK_REFILL || (exists && resident))
      else $error("AST_REFILL_NEEDS_BOTH"); // R4
    assert (exists || outcome == WALK_ILLEGAL)
      else $error("AST_ABSENT_IS_ILLEGAL"); // R6
  end

endmodule

// File: rtl/pgwalk_ctrl.sv
module pgwalk_ctrl
  import pgwalk_pkg::*;
#(
  parameter int unsigned VPN_W     = 20,
  parameter int unsigned PPN_W     = 20,
  parameter int unsigned ADDR_W    = 32,
  parameter int unsigned WORD_W    = 32,
  parameter int unsigned VPN_LIMIT = 32'h000B_FFFF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              miss_req,
  input  logic [VPN_W-1:0]  miss_vpn,
  input  logic [ADDR_W-1:0] dir_base,
  input  logic              mem_rvalid,
  input  logic [WORD_W-1:0] mem_rdata,
  input  walk_res_e         dec_outcome,
  input  logic [PPN_W-1:0]  dec_ppn,
  output logic              sel_table,
  output logic              rd_en,
  output logic              busy,
  output logic              done,
  output walk_res_e         res_q,
  output logic [PPN_W-1:0]  ppn_q,
  output logic [VPN_W-1:0]  vpn_q,
  output logic [ADDR_W-1:0] base_q,
  output logic [ADDR_W-1:0] tbl_q
);

  walk_state_e state_q;
  walk_state_e state_nxt;

  logic             accept;
  logic             out_range;
  logic             tbl_ld;
  logic             res_ld;
  walk_res_e        res_nxt;
  logic [PPN_W-1:0] ppn_nxt;

  assign out_range = 32'(miss_vpn) > VPN_LIMIT;
  assign accept    = (state_q == ST_IDLE) && miss_req;

  always_comb begin
    state_nxt = state_q;
    sel_table = 1'b0;
    rd_en     = 1'b0;
    tbl_ld    = 1'b0;
    res_ld    = 1'b0;
    res_nxt   = WALK_ILLEGAL;
    ppn_nxt   = '0;
    case (state_q)
      ST_IDLE: begin
        if (miss_req) begin
          if (out_range) begin
            state_nxt = ST_DONE;
            res_ld    = 1'b1;
          end else begin
            state_nxt = ST_DIR;
          end
        end
      end
      ST_DIR: begin
        rd_en = 1'b1;
        if (mem_rvalid) begin
          if (mem_rdata == '0) begin
            state_nxt = ST_DONE;
            res_ld    = 1'b1;
          end else begin
            state_nxt = ST_PTE;
            tbl_ld    = 1'b1;
          end
        end
      end
      ST_PTE: begin
        rd_en     = 1'b1;
        sel_table = 1'b1;
        if (mem_rvalid) begin
          state_nxt = ST_DONE;
          res_ld    = 1'b1;
          res_nxt   = dec_outcome;
          ppn_nxt   = dec_ppn;
        end
      end
      ST_DONE: state_nxt = ST_IDLE;
      default: state_nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_nxt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vpn_q  <= '0;
      base_q <= '0;
    end else if (accept) begin
      vpn_q  <= miss_vpn;
      base_q <= dir_base;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      tbl_q <= '0;
    else if (tbl_ld) tbl_q <= ADDR_W'(mem_rdata);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_q <= WALK_REFILL;
      ppn_q <= '0;
    end else if (res_ld) begin
      res_q <= res_nxt;
      ppn_q <= ppn_nxt;
    end
  end

  assign busy = (state_q != ST_IDLE);
  assign done = (state_q == ST_DONE);

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done) else $error("AST_DONE_ONE_CYCLE"); // R8

  AST_DONE_INSIDE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> busy) else $error("AST_DONE_INSIDE_BUSY"); // R9

  AST_RANGE_AT_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && miss_req && out_range) |=> (done && res_q == WALK_ILLEGAL))
    else $error("AST_RANGE_AT_ONCE"); // R7

  AST_BUSY_IGNORES_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done) |=> $stable(vpn_q)) else $error("AST_BUSY_IGNORES_REQ"); // R10

endmodule

// File: rtl/pgwalk_top.sv
module pgwalk_top
  import pgwalk_pkg::*;
#(
  parameter int unsigned VPN_W     = 20,
  parameter int unsigned DIR_IDX_W = 10,
  parameter int unsigned PPN_W     = 20,
  parameter int unsigned ADDR_W    = 32,
  parameter int unsigned WORD_W    = 32,
  parameter int unsigned VPN_LIMIT = 32'h000B_FFFF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              miss_req,
  input  logic [VPN_W-1:0]  miss_vpn,
  input  logic [ADDR_W-1:0] dir_base,
  output logic              mem_rd_en,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic              mem_rvalid,
  input  logic [WORD_W-1:0] mem_rdata,
  output logic              busy,
  output logic              done,
  output logic [1:0]        result,
  output logic [PPN_W-1:0]  res_ppn,
  output logic [VPN_W-1:0]  res_vpn
);

  localparam int unsigned WORD_SHIFT = $clog2(WORD_W / 8);

  logic              rst_n_sync;
  logic              sel_table;
  walk_res_e         dec_outcome;
  logic [PPN_W-1:0]  dec_ppn;
  walk_res_e         res_q;
  logic [ADDR_W-1:0] base_q;
  logic [ADDR_W-1:0] tbl_q;

  pgwalk_rstsync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_sync)
  );

  pgwalk_decode #(.WORD_W(WORD_W), .PPN_W(PPN_W)) u_dec (
    .entry   (mem_rdata),
    .outcome (dec_outcome),
    .ppn     (dec_ppn)
  );

  pgwalk_ctrl #(
    .VPN_W(VPN_W), .PPN_W(PPN_W), .ADDR_W(ADDR_W),
    .WORD_W(WORD_W), .VPN_LIMIT(VPN_LIMIT)
  ) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n_sync),
    .miss_req    (miss_req),
    .miss_vpn    (miss_vpn),
    .dir_base    (dir_base),
    .mem_rvalid  (mem_rvalid),
    .mem_rdata   (mem_rdata),
    .dec_outcome (dec_outcome),
    .dec_ppn     (dec_ppn),
    .sel_table   (sel_table),
    .rd_en       (mem_rd_en),
    .busy        (busy),
    .done        (done),
    .res_q       (res_q),
    .ppn_q       (res_ppn),
    .vpn_q       (res_vpn),
    .base_q      (base_q),
    .tbl_q       (tbl_q)
  );

  pgwalk_addr #(
    .VPN_W(VPN_W), .DIR_IDX_W(DIR_IDX_W), .ADDR_W(ADDR_W), .WORD_SHIFT(WORD_SHIFT)
  ) u_addr (
    .sel_table  (sel_table),
    .vpn        (res_vpn),
    .dir_base   (base_q),
    .table_base (tbl_q),
    .addr       (mem_addr)
  );

  assign result = res_q;

  AST_READ_HELD: assert property (@(posedge clk) disable iff (!rst_n_sync)
    (mem_rd_en && !mem_rvalid) |=> (mem_rd_en && $stable(mem_addr)))
    else $error("AST_READ_HELD"); // R11

  AST_IDLE_NO_READ: assert property (@(posedge clk) disable iff (!rst_n_sync)
    !busy |-> !mem_rd_en) else $error("AST_IDLE_NO_READ"); // R9

  AST_NO_PPN_UNLESS_REFILL: assert property (@(posedge clk) disable iff (!rst_n_sync)
    (done && result != 2'd0) |-> (res_ppn == '0))
    else $error("AST_NO_PPN_UNLESS_REFILL"); // R5

  AST_CODE_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n_sync)
    done |-> (result != 2'd3)) else $error("AST_CODE_IN_RANGE"); // R7

endmodule

// File: tb/tb_pgwalk_top.sv
module tb_pgwalk_top;

  typedef struct packed {
    logic [19:0] vpn;
    logic [31:0] base;
    logic [31:0] pde;
    logic [31:0] pte;
    logic [3:0]  lat;
    logic [1:0]  res;
    logic [19:0] ppn;
    logic [1:0]  reads;
  } vec_t;

  localparam int NV = 11;
  localparam vec_t VECS [NV] = '{
    '{20'h00400, 32'h0000_8000, 32'h0001_0000, 32'h00D9_2777, 4'd1, 2'd0, 20'h92777, 2'd2},
    '{20'h00401, 32'h0000_8000, 32'h0001_0000, 32'h0089_A9A0, 4'd3, 2'd1, 20'h00000, 2'd2},
    '{20'h10012, 32'h0000_8000, 32'h0003_0000, 32'h0000_0000, 4'd2, 2'd2, 20'h00000, 2'd2},
    '{20'h20345, 32'h0000_8000, 32'h0000_0000, 32'h00F1_1111, 4'd2, 2'd2, 20'h00000, 2'd1},
    '{20'hC0000, 32'h0000_8000, 32'h0001_0000, 32'h00F1_1111, 4'd1, 2'd2, 20'h00000, 2'd0},
    '{20'hBFFFF, 32'h0000_8000, 32'h0004_0000, 32'h00E8_1F23, 4'd1, 2'd0, 20'h81F23, 2'd2},
    '{20'h00402, 32'h0000_8000, 32'h0001_0000, 32'h0041_2345, 4'd1, 2'd2, 20'h00000, 2'd2},
    '{20'hFFFFF, 32'h0000_8000, 32'h0001_0000, 32'h00F1_1111, 4'd1, 2'd2, 20'h00000, 2'd0},
    '{20'h7FFFE, 32'h0000_8000, 32'h0005_0000, 32'hFFCA_BCDE, 4'd4, 2'd0, 20'hABCDE, 2'd2},
    '{20'h00010, 32'h0000_8000, 32'h0006_0000, 32'h5A80_0001, 4'd2, 2'd1, 20'h00000, 2'd2},
    '{20'h3FF01, 32'h0000_0FFC, 32'h0002_0004, 32'h00F0_0042, 4'd2, 2'd0, 20'h00042, 2'd2}
  };

  logic        clk;
  logic        rst_n;
  logic        miss_req;
  logic [19:0] miss_vpn;
  logic [31:0] dir_base;
  logic        mem_rd_en;
  logic [31:0] mem_addr;
  logic        mem_rvalid;
  logic [31:0] mem_rdata;
  logic        busy;
  logic        done;
  logic [1:0]  result;
  logic [19:0] res_ppn;
  logic [19:0] res_vpn;

  int n_checks = 0;
  int n_fails  = 0;

  pgwalk_top dut (
    .clk(clk), .rst_n(rst_n), .miss_req(miss_req), .miss_vpn(miss_vpn),
    .dir_base(dir_base), .mem_rd_en(mem_rd_en), .mem_addr(mem_addr),
    .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata), .busy(busy), .done(done),
    .result(result), .res_ppn(res_ppn), .res_vpn(res_vpn)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // Outcome of the last walk
  vec_t        cur;
  logic [1:0]  got_res;
  logic [19:0] got_ppn;
  logic [19:0] got_vpn;
  int          got_reads;
  int          got_cyc;
  bit          addr_bad;
  bit          busy_bad;
  bit          saw_done;

  function automatic logic [31:0] lookup(input logic [31:0] a);
    logic [31:0] da;
    logic [31:0] pa;
    da = cur.base + {20'd0, cur.vpn[19:10], 2'b00};
    pa = cur.pde  + {20'd0, cur.vpn[9:0], 2'b00};
    if (a == da)      return cur.pde;
    else if (a == pa) return cur.pte;
    addr_bad = 1'b1;
    return 32'hDEAD_BEEF;
  endfunction

  task automatic walk(input vec_t v, input bit inject);
    int w;
    cur       = v;
    got_reads = 0;
    got_cyc   = -1;
    addr_bad  = 1'b0;
    busy_bad  = 1'b0;
    saw_done  = 1'b0;
    w         = 0;
    @(negedge clk);
    miss_req = 1'b1;
    miss_vpn = v.vpn;
    dir_base = v.base;
    @(negedge clk);
    miss_req = 1'b0;
    for (int i = 0; i < 64; i++) begin
      mem_rvalid = 1'b0;
      if (inject) begin
        miss_req = (i == 0);
        if (i == 0) miss_vpn = 20'hC0000;
      end
      if (!busy) busy_bad = 1'b1;
      if (done) begin
        saw_done = 1'b1;
        got_cyc  = i;
        got_res  = result;
        got_ppn  = res_ppn;
        got_vpn  = res_vpn;
        if (inject) miss_req = 1'b1;
        break;
      end
      if (mem_rd_en) begin
        w++;
        if (w >= int'(v.lat)) begin
          mem_rvalid = 1'b1;
          mem_rdata  = lookup(mem_addr);
          got_reads++;
          w = 0;
        end
      end
      @(negedge clk);
    end
    mem_rvalid = 1'b0;
    @(negedge clk);
    miss_req = 1'b0;
    chk(!done && !busy, "R8 R9 strobe ends and idle after done",
        {30'd0, done, busy}, 32'd0);
  endtask

  task automatic check_walk(input vec_t v);
    chk(saw_done, "R8 done seen", {31'd0, saw_done}, 32'd1);
    chk(got_res == v.res, "R3/R4/R5/R6/R7 result code", {30'd0, got_res}, {30'd0, v.res});
    chk(got_ppn == v.ppn, "R4/R5 res_ppn", {12'd0, got_ppn}, {12'd0, v.ppn});
    chk(got_vpn == v.vpn, "R4 res_vpn echo", {12'd0, got_vpn}, {12'd0, v.vpn});
    chk(got_reads == int'(v.reads), "R3/R7 read count", got_reads, {30'd0, v.reads});
    chk(got_cyc == int'(v.reads) * int'(v.lat), "R11 cycles to done",
        got_cyc, int'(v.reads) * int'(v.lat));
    chk(!addr_bad, "R1 R2 read address", {31'd0, addr_bad}, 32'd0);
    chk(!busy_bad, "R9 busy through walk", {31'd0, busy_bad}, 32'd0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_checks++;
    n_fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
    $finish;
  end

  initial begin
    rst_n      = 1'b0;
    miss_req   = 1'b0;
    miss_vpn   = '0;
    dir_base   = '0;
    mem_rvalid = 1'b0;
    mem_rdata  = '0;
    repeat (3) @(negedge clk);
    chk(!busy && !done && !mem_rd_en, "R12 reset outputs",
        {29'd0, busy, done, mem_rd_en}, 32'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(!busy && !done && !mem_rd_en, "R12 after release",
        {29'd0, busy, done, mem_rd_en}, 32'd0);

    for (int k = 0; k < NV; k++) begin
      walk(VECS[k], 1'b0);
      check_walk(VECS[k]);
    end

    // R10: a request during the walk and in the done cycle is ignored
    walk(VECS[0], 1'b1);
    check_walk(VECS[0]);
    repeat (3) @(negedge clk);
    chk(!busy && !mem_rd_en, "R10 no extra walk after ignored request",
        {30'd0, busy, mem_rd_en}, 32'd0);

    // R12: reset cuts a walk short
    @(negedge clk);
    miss_req = 1'b1;
    miss_vpn = 20'h00400;
    dir_base = 32'h0000_8000;
    @(negedge clk);
    miss_req = 1'b0;
    chk(busy && mem_rd_en, "R12 walk started before reset",
        {30'd0, busy, mem_rd_en}, 32'd3);
    rst_n = 1'b0;
    #1;
    chk(!busy && !done && !mem_rd_en, "R12 reset mid-walk",
        {29'd0, busy, done, mem_rd_en}, 32'd0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(!busy && !mem_rd_en, "R12 idle after mid-walk reset",
        {30'd0, busy, mem_rd_en}, 32'd0);

    // Walk still works after reset
    walk(VECS[5], 1'b0);
    check_walk(VECS[5]);

    $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
    $finish;
  end

endmodule